// File: doc/BRIEF.md
# Request/Acknowledge Byte Port

This block moves single bytes between a fast on-chip master and a slow peripheral that runs on its own timing. The master issues a one-cycle write or read command and watches a busy flag. Toward the peripheral, the block runs a four-phase level handshake, and each direction uses its own signal order.

For a write, the block first raises a request line. It then waits, polling, until the peripheral's acknowledge arrives. Only after that does it place the byte on the data lines and drop the request. It keeps driving the byte until the acknowledge returns low.

For a read, the block waits until the peripheral raises its own ready line. It then answers with a valid strobe. When the peripheral drops ready, the block captures the 8-bit bus and releases the strobe.

Both peripheral control inputs pass through two-flop synchronizers. A programmable limit can abandon a write whose acknowledge never comes and raise an error flag.

Top module: `hs_pport`

## Requirements
- R1: During and after reset, busy, err, rd_valid, prq, pd_oe and pvld are low and rd_data is zero.
- R2: A cmd_wr seen at a clock edge while idle sets busy and prq from the next cycle, keeps pd_oe low, and clears err.
- R3: While the synchronized acknowledge is low, prq stays high and pd_oe stays low.
- R4: pack passes through two flops: if pack is first sampled high at edge k, prq falls and pd_oe rises after edge k+2.
- R5: Once the acknowledge is seen, the full 8-bit written byte is driven on pd_out with pd_oe high and prq low. This holds until the synchronized acknowledge is low, after which pd_oe and busy fall together.
- R6: A cmd_rd seen while idle sets busy. pvld rises two edges after prdy is first sampled high, and not before.
- R7: While pvld is high, the block waits for the synchronized ready to fall. It then stores pd_in into rd_data, pulses rd_valid for exactly one cycle, and drops pvld and busy.
- R8: Commands that arrive while busy have no effect. When cmd_wr and cmd_rd arrive together while idle, the write is taken.
- R9: With tmo_limit nonzero, a write that spends tmo_limit cycles requesting without a synchronized acknowledge sets err, drops prq and returns to idle. A tmo_limit of zero disables this. err clears on the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | One-cycle write command |
| cmd_rd | input | 1 | One-cycle read command |
| wr_data | input | DW | Byte to write, taken with cmd_wr |
| tmo_limit | input | TW | Acknowledge wait limit in cycles, 0 disables |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last write abandoned on timeout |
| rd_data | output | DW | Last captured read byte |
| rd_valid | output | 1 | One-cycle pulse when rd_data updates |
| prq | output | 1 | Write request toward peripheral |
| pack | input | 1 | Peripheral acknowledge, asynchronous |
| pd_out | output | DW | Outgoing byte |
| pd_oe | output | 1 | Drive enable for pd_out |
| prdy | input | 1 | Peripheral has data, asynchronous |
| pvld | output | 1 | Valid strobe answering prdy |
| pd_in | input | DW | Incoming byte from shared bus |

## Verification
The assertions assume the peripheral follows the handshake. It holds pd_in steady for as long as pvld is high. It moves pack and prdy as clean levels, each held long enough to cross the two synchronizer flops. The master keeps tmo_limit constant during a write. The bench changes every input only on the falling edge and holds each peripheral level for several cycles. It changes tmo_limit only while the port is idle, so every transition that the properties rely on is seen cleanly.

// File: rtl/hs_pport.sv
module hs_pport #(
  parameter int DW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_rd,
  input  logic [DW-1:0] wr_data,
  input  logic [TW-1:0] tmo_limit,
  output logic          busy,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          prq,
  input  logic          pack,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic          prdy,
  output logic          pvld,
  input  logic [DW-1:0] pd_in
);

  typedef enum logic [2:0] {S_IDLE, S_OREQ, S_ODAT, S_IWAIT, S_IVLD} st_t;

  st_t           st, st_nx;
  logic [1:0]    ack_ff, rdy_ff;
  logic [TW-1:0] cnt;
  logic [DW-1:0] wbuf;
  logic          ack_s, rdy_s, tmo_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_ff <= '0;
      rdy_ff <= '0;
    end else begin
      ack_ff <= {ack_ff[0], pack};
      rdy_ff <= {rdy_ff[0], prdy};
    end

  assign ack_s   = ack_ff[1];
  assign rdy_s   = rdy_ff[1];
  assign tmo_hit = (tmo_limit != '0) && (cnt == tmo_limit - TW'(1));

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (cmd_wr) st_nx = S_OREQ;
               else if (cmd_rd) st_nx = S_IWAIT;
      S_OREQ:  if (ack_s) st_nx = S_ODAT;
               else if (tmo_hit) st_nx = S_IDLE;
      S_ODAT:  if (!ack_s) st_nx = S_IDLE;
      S_IWAIT: if (rdy_s) st_nx = S_IVLD;
      S_IVLD:  if (!rdy_s) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      wbuf     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      st       <= st_nx;
      rd_valid <= 1'b0;
      if (st == S_IDLE && (cmd_wr || cmd_rd)) err <= 1'b0;
      if (st == S_IDLE && cmd_wr) begin
        wbuf <= wr_data;
        cnt  <= '0;
      end
      if (st == S_OREQ && !ack_s) begin
        if (tmo_hit) err <= 1'b1;
        else         cnt <= cnt + TW'(1);
      end
      if (st == S_IVLD && !rdy_s) begin
        rd_data  <= pd_in;
        rd_valid <= 1'b1;
      end
    end

  assign busy   = (st != S_IDLE);
  assign prq    = (st == S_OREQ);
  assign pd_oe  = (st == S_ODAT);
  assign pvld   = (st == S_IVLD);
  assign pd_out = pd_oe ? wbuf : '0;

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr || cmd_rd)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prq && !ack_s && tmo_limit == '0) |=> prq); // R3
  AST_OE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_oe) |-> $past(ack_ff[1])); // R4
  AST_OE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_oe && prq)); // R5
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pd_oe |=> (!pd_oe || $stable(pd_out))); // R5
  AST_VLD_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pvld) |-> $past(rdy_ff[1])); // R6
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7
  AST_ERR_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(tmo_limit != '0)); // R9

endmodule

// File: tb/hs_pport_tb.sv
module hs_pport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 5000;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, cmd_rd = 0, pack = 0, prdy = 0;
  logic [7:0] wr_data = 0, pd_in = 0;
  logic [15:0] tmo_limit = 0;
  logic busy, err, rd_valid, prq, pd_oe, pvld;
  logic [7:0] rd_data, pd_out;

  hs_pport u_dut (.clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .wr_data(wr_data), .tmo_limit(tmo_limit), .busy(busy), .err(err),
    .rd_data(rd_data), .rd_valid(rd_valid), .prq(prq), .pack(pack),
    .pd_out(pd_out), .pd_oe(pd_oe), .prdy(prdy), .pvld(pvld), .pd_in(pd_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  string cur_req = "R1";
  bit running = 0;

  // behavioural reference: pipelines of sampled levels plus a phase number
  int m_ph, m_cnt;
  bit ackq[$], rdyq[$];
  bit [7:0] m_wb, m_rd;
  bit m_rv, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_wb = 0; m_rd = 0; m_rv = 0; m_err = 0;
      ackq = '{0, 0}; rdyq = '{0, 0};
    end else begin
      bit a, r;
      a = ackq[0]; r = rdyq[0];
      m_rv = 0;
      case (m_ph)
        0: if (cmd_wr) begin m_ph = 1; m_wb = wr_data; m_err = 0; m_cnt = 0; end
           else if (cmd_rd) begin m_ph = 3; m_err = 0; end
        1: if (a) m_ph = 2;
           else if (tmo_limit != 0 && m_cnt + 1 >= int'(tmo_limit)) begin m_err = 1; m_ph = 0; end
           else m_cnt++;
        2: if (!a) m_ph = 0;
        3: if (r) m_ph = 4;
        default: if (!r) begin m_rd = pd_in; m_rv = 1; m_ph = 0; end
      endcase
      void'(ackq.pop_front()); ackq.push_back(pack);
      void'(rdyq.pop_front()); rdyq.push_back(prdy);
    end
  end

  task automatic chk(string nm, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk("busy", busy, m_ph != 0);
    chk("prq", prq, m_ph == 1);
    chk("pd_oe", pd_oe, m_ph == 2);
    if (m_ph == 2) chk("pd_out", pd_out, m_wb);
    chk("pvld", pvld, m_ph == 4);
    chk("rd_data", rd_data, m_rd);
    chk("rd_valid", rd_valid, m_rv);
    chk("err", err, m_err);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit w, bit rd, logic [7:0] d);
    cmd_wr = w; cmd_rd = rd; wr_data = d;
    @(negedge clk);
    cmd_wr = 0; cmd_rd = 0;
  endtask

  initial begin
    idle(3);
    cur_req = "R1";
    chk("busy", busy, 0); chk("prq", prq, 0); chk("pd_oe", pd_oe, 0);
    chk("pvld", pvld, 0); chk("err", err, 0); chk("rd_data", rd_data, 0);
    rst_n = 1;
    running = 1;
    idle(2);
    // write with slow acknowledge
    cur_req = "R2"; pulse(1, 0, 8'hA5);
    cur_req = "R3"; idle(6);
    cur_req = "R4"; pack = 1; idle(5);
    cur_req = "R5"; pack = 0; idle(5);
    // both commands together, then commands while busy
    cur_req = "R8"; pulse(1, 1, 8'h5A);
    pulse(0, 1, 8'h00); pulse(1, 0, 8'hFF); idle(2);
    pack = 1; idle(3); pulse(1, 0, 8'h11); idle(2);
    pack = 0; idle(5);
    // read transfers
    cur_req = "R6"; pulse(0, 1, 8'h00); idle(4);
    pd_in = 8'h3C; prdy = 1; idle(6);
    cur_req = "R7"; prdy = 0; idle(5); pd_in = 8'h00;
    cur_req = "R6"; pd_in = 8'hC3; prdy = 1; idle(4);
    pulse(0, 1, 8'h00); idle(5);
    cur_req = "R7"; prdy = 0; idle(5);
    // timeout then recovery
    cur_req = "R9"; tmo_limit = 16'd6; pulse(1, 0, 8'h77); idle(12);
    tmo_limit = 16'd0; pulse(1, 0, 8'h81); idle(20);
    pack = 1; idle(5); pack = 0; idle(5);
    tmo_limit = 16'd3; pulse(1, 0, 8'h42); idle(1); pack = 1; idle(6);
    pack = 0; idle(5);
    running = 0;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule